// File: doc/BRIEF.md
# Double-Buffered Serial-to-Parallel Output Register

This block collects a serial bit stream into a shift stage, one bit per rising edge of a shift strobe. A second strobe copies the whole shift stage into a holding register in one step. Only the holding register drives the parallel outputs, so they stay steady while the next word is being loaded. The last shift stage is also presented on a chain output. Feeding it into the serial input of another instance builds a longer register.

Both strobes are ordinary input levels. They pass through synchronizers and rising-edge detectors on the single system clock. An active-low clear empties only the shift stage. It acts at once and is released in step with the clock. An active-low output enable selects between driven outputs and high impedance. High impedance is modelled as a data vector plus a drive flag.

Top module: `spo_reg`

## Requirements
- R1: On each detected rising edge of `shift_stb`, `ser_in` enters stage 0 and every other bit moves one position toward stage 7. A strobe level that is set away from a clock edge has completed its shift after three rising clock edges.
- R2: On each detected rising edge of `store_stb`, all eight shift-stage bits are copied into the holding register at once. The copy is visible on `par_data` three rising clock edges after the strobe is raised.
- R3: `par_data` changes only on a store event. Shifting, clearing and changes of `oe_n` leave it unchanged.
- R4: While `clr_n` is low, the shift stage reads all zeros without waiting for a clock edge, and `chain_out` reads 0. Shift strobes in that time have no effect, and the holding register keeps its value.
- R5: With `oe_n` high, `par_en` is 0, meaning all eight parallel outputs are high impedance. With `oe_n` low, `par_en` is 1 and `par_data` carries the holding register.
- R6: `chain_out` always equals shift stage 7, whatever the state of `oe_n`.
- R7: A strobe held high for many clocks causes exactly one action.
- R8: If a shift event and a store event arrive in the same cycle, the holding register takes the shift-stage contents from before that shift.
- R9: While `rst_n` is low, both the shift stage and the holding register are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| ser_in | input | 1 | Serial data bit |
| shift_stb | input | 1 | Shift strobe; each rising edge shifts in one bit |
| store_stb | input | 1 | Store strobe; each rising edge copies the shift stage to the outputs |
| clr_n | input | 1 | Active-low clear of the shift stage only |
| oe_n | input | 1 | Active-low output enable |
| par_data | output | 8 | Holding register value (parallel outputs) |
| par_en | output | 1 | 1 when the parallel outputs are driven, 0 when high impedance |
| chain_out | output | 1 | Shift stage 7, for chaining |

## Verification
Every 8-bit value is shifted in, most significant bit first, and then stored. After each shift, `chain_out` is compared with a model of the shift stage kept in the bench, and `par_data` is compared with the previously stored word. This separates a wrong shift direction or bit order from outputs that leak before a store. Further patterns cover a strobe held high for a long time (one action, not several), both strobes raised together (the pre-shift word is captured), a clear in the middle of loading with strobes during the clear, and an output disable while bits are shifting. These show that clear and enable each touch only their own stage.

// File: rtl/spo_pkg.sv
package spo_pkg;
    // strobe events detected on the system clock
    typedef struct packed {
        logic shift;
        logic store;
    } spo_evt_t;
endpackage

// File: rtl/spo_strobe_sync.sv
module spo_strobe_sync #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb_in,
    output logic rise
);
    localparam int DEPTH = SYNC + 1;

    logic [DEPTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[DEPTH-2:0], stb_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign rise = pipe_q[SYNC-1] & ~pipe_q[SYNC];
endmodule

// File: rtl/spo_clr_sync.sv
module spo_clr_sync #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rel_n
);
    logic [SYNC-1:0] q_d, q_q;

    always_comb begin
        q_d = {q_q[SYNC-2:0], 1'b1};
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) q_q <= '0;
        else         q_q <= q_d;
    end

    assign rel_n = q_q[SYNC-1];
endmodule

// File: rtl/spo_reg.sv
module spo_reg
    import spo_pkg::*;
#(
    parameter int W    = 8,
    parameter int SYNC = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ser_in,
    input  logic         shift_stb,
    input  logic         store_stb,
    input  logic         clr_n,
    input  logic         oe_n,
    output logic [W-1:0] par_data,
    output logic         par_en,
    output logic         chain_out
);
    typedef struct packed {
        logic [W-1:0] sr;
    } shift_t;

    typedef struct packed {
        logic [W-1:0] hr;
    } hold_t;

    spo_evt_t evt;
    logic     clr_arst_n;
    logic     shift_rst_n;
    shift_t   shift_d, shift_q;
    hold_t    hold_d, hold_q;

    spo_strobe_sync #(.SYNC(SYNC)) u_shift_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .stb_in (shift_stb),
        .rise   (evt.shift)
    );

    spo_strobe_sync #(.SYNC(SYNC)) u_store_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .stb_in (store_stb),
        .rise   (evt.store)
    );

    // clear asserts at once, releases on the clock
    assign clr_arst_n = rst_n & clr_n;

    spo_clr_sync #(.SYNC(SYNC)) u_clr_sync (
        .clk    (clk),
        .arst_n (clr_arst_n),
        .rel_n  (shift_rst_n)
    );

    always_comb begin
        shift_d = shift_q;
        hold_d  = hold_q;
        if (evt.shift) shift_d.sr = {shift_q.sr[W-2:0], ser_in};
        // store takes the pre-shift word when both events coincide
        if (evt.store) hold_d.hr = shift_q.sr;
    end

    always_ff @(posedge clk or negedge shift_rst_n) begin
        if (!shift_rst_n) shift_q <= '0;
        else              shift_q <= shift_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign par_data  = hold_q.hr;
    assign par_en    = ~oe_n;
    assign chain_out = shift_q.sr[W-1];
endmodule

// File: rtl/spo_reg_chk.sv
module spo_reg_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         ser_in,
    input logic         clr_n,
    input logic         oe_n,
    input logic         sh_evt,
    input logic         st_evt,
    input logic         rel_n,
    input logic [W-1:0] sr,
    input logic [W-1:0] hr,
    input logic [W-1:0] par_data,
    input logic         par_en,
    input logic         chain_out
);
    // R1
    shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_evt && rel_n && clr_n) |=> (!clr_n || sr == {$past(sr[W-2:0]), $past(ser_in)}));

    // R2
    store_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_evt |=> (hr == $past(sr)));

    // R3
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_evt |=> $stable(hr));

    // R4
    clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rel_n |-> (sr == '0 && chain_out == 1'b0));

    // R5
    oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !par_en);

    // R5
    oe_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> (par_en && par_data == hr));

    // R6
    chain_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chain_out == sr[W-1]);

    // R7
    single_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sh_evt |=> !sh_evt);

    // R7
    single_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_evt |=> !st_evt);

    // R8
    same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_evt && st_evt) |=> (hr == $past(sr)));
endmodule

bind spo_reg spo_reg_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_in    (ser_in),
    .clr_n     (clr_n),
    .oe_n      (oe_n),
    .sh_evt    (evt.shift),
    .st_evt    (evt.store),
    .rel_n     (shift_rst_n),
    .sr        (shift_q.sr),
    .hr        (hold_q.hr),
    .par_data  (par_data),
    .par_en    (par_en),
    .chain_out (chain_out)
);

// File: tb/spo_reg_tb.sv
module spo_reg_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_in = 1'b0;
    logic       shift_stb = 1'b0;
    logic       store_stb = 1'b0;
    logic       clr_n = 1'b1;
    logic       oe_n = 1'b0;
    logic [7:0] par_data;
    logic       par_en;
    logic       chain_out;

    int total = 0;
    int bad   = 0;
    logic [7:0] exp_sr = 8'h00;
    logic [7:0] exp_hr = 8'h00;

    always #2 clk = ~clk;

    spo_reg u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_in    (ser_in),
        .shift_stb (shift_stb),
        .store_stb (store_stb),
        .clr_n     (clr_n),
        .oe_n      (oe_n),
        .par_data  (par_data),
        .par_en    (par_en),
        .chain_out (chain_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clocks(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_shift(input logic b);
        ser_in    = b;
        shift_stb = 1'b1;
        clocks(3);
        shift_stb = 1'b0;
        clocks(3);
        exp_sr = {exp_sr[6:0], b};
    endtask

    task automatic do_store();
        store_stb = 1'b1;
        clocks(3);
        store_stb = 1'b0;
        clocks(3);
        exp_hr = exp_sr;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R9 reset state
        clocks(3);
        check("R9 par_data in reset", par_data, 8'h00);
        check("R9 chain_out in reset", chain_out, 1'b0);
        check("R5 par_en with oe_n low", par_en, 1'b1);
        rst_n = 1'b1;
        clocks(4);

        // R1 R2 R3 R6 sweep of every word, MSB first
        for (int v = 0; v < 256; v++) begin
            for (int i = 7; i >= 0; i--) begin
                do_shift(v[i]);
                check("R6 chain_out tracks stage 7", chain_out, exp_sr[7]);
                check("R3 par_data held while shifting", par_data, exp_hr);
            end
            do_store();
            check("R2 R1 stored word", par_data, v[7:0]);
        end

        // R7 long strobe gives one shift and one store
        clr_n = 1'b0; clocks(1); clr_n = 1'b1; clocks(3);
        exp_sr = 8'h00;
        ser_in = 1'b1;
        shift_stb = 1'b1;
        clocks(12);
        shift_stb = 1'b0;
        clocks(3);
        exp_sr = 8'h01;
        store_stb = 1'b1;
        clocks(12);
        store_stb = 1'b0;
        clocks(3);
        exp_hr = exp_sr;
        check("R7 one shift per held strobe", par_data, 8'h01);

        // R8 simultaneous shift and store
        for (int i = 7; i >= 0; i--) do_shift(i[0] ? 1'b1 : 1'b0); // 0xAA
        check("R8 setup stage 7", chain_out, 1'b1);
        ser_in = 1'b1;
        shift_stb = 1'b1;
        store_stb = 1'b1;
        clocks(3);
        shift_stb = 1'b0;
        store_stb = 1'b0;
        clocks(3);
        check("R8 pre-shift word captured", par_data, 8'hAA);
        exp_sr = 8'h55;
        do_store();
        check("R8 shift still applied", par_data, 8'h55);

        // R4 clear empties shift stage only
        for (int i = 7; i >= 0; i--) do_shift(i[0] ? 1'b0 : 1'b1); // 0x55
        do_shift(1'b1);
        check("R4 setup chain_out", chain_out, 1'b1);
        #1 clr_n = 1'b0;
        #1;
        check("R4 chain_out zero without a clock", chain_out, 1'b0);
        check("R4 holding register untouched", par_data, 8'h55);
        clocks(1);
        ser_in = 1'b1;
        shift_stb = 1'b1;
        clocks(3);
        shift_stb = 1'b0;
        clocks(3);
        check("R4 shift ignored during clear", chain_out, 1'b0);
        clr_n = 1'b1;
        clocks(3);
        exp_sr = 8'h00;
        check("R3 par_data kept across clear", par_data, 8'h55);
        do_store();
        check("R4 cleared stage stored", par_data, 8'h00);

        // R5 R6 output enable
        do_shift(1'b1);
        oe_n = 1'b1;
        clocks(1);
        check("R5 par_en low when disabled", par_en, 1'b0);
        for (int i = 0; i < 7; i++) begin
            do_shift(1'b0);
            check("R6 chain_out while disabled", chain_out, exp_sr[7]);
        end
        check("R6 bit reached stage 7", chain_out, 1'b1);
        do_store();
        check("R5 par_en stays low after store", par_en, 1'b0);
        oe_n = 1'b0;
        clocks(1);
        check("R5 par_en back on", par_en, 1'b1);
        check("R5 outputs show holding register", par_data, 8'h80);

        // R9 reset clears both stages
        rst_n = 1'b0;
        clocks(2);
        check("R9 par_data after reset", par_data, 8'h00);
        check("R9 chain_out after reset", chain_out, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule